// File: doc/BRIEF.md
# Amplifier Fault and Shutdown Controller

This block decides when a bridge-type class-D output stage may switch. It takes an active-low shutdown request, a short-circuit detect flag from the output stage, a digital die-temperature code and a periodic tick that serves as its timebase. From these it produces an output-enable for the modulator, a low-power indication and two fault status bits. Analog sensing, the bias ramp and the power transistors are outside the block.

Two protection paths work side by side. A short-circuit that persists for a set number of ticks stops the outputs and is held until the shutdown request has been driven low and then high again. If the short is still there after that toggle, the block trips again. An over-temperature condition also stops the outputs, but it clears by itself once the die has cooled by a hysteresis margin. Every release, whether from shutdown or from a thermal fault, passes through a start-up wait of a fixed tick count plus a programmable extension before the output stage is enabled.

Top module: `amp_guard_ctrl`

## Requirements
- R1: While the synchronised shutdown request is low, `out_en` is 0 and `lowpwr` is 1. After `sd_n` falls while enabled, `out_en` is 0 within four clocks.
- R2: `out_en` is 1 only in the running state. In that state `lowpwr`, `fault_short` and `fault_therm` are all 0.
- R3: After a release, `out_en` stays 0 until `FIX_TICKS + ramp_extra` ticks have been counted in the start-up state. With the defaults, FIX_TICKS is 82 and `ramp_extra` is an unsigned 6-bit count. `ramp_extra` is read live during the wait.
- R4: `short_det` held high over `DEB_TICKS` ticks (default 4) trips the short fault. `out_en` then drops, and `fault_short` and `lowpwr` go to 1. A high pulse spanning fewer ticks resets the count and has no effect.
- R5: The short fault stays latched after `short_det` returns low, and also while `sd_n` is low. It clears only on a rising edge of the synchronised `sd_n`, which leads into start-up.
- R6: If `short_det` is still high when the fault is released, the fault trips again and `out_en` never rises.
- R7: `fault_therm` rises once `temp_code` exceeds 150 and then holds `out_en` at 0. It falls only when `temp_code` is at or below 135. A code of exactly 150 does not trip it.
- R8: When the thermal fault clears, the block runs a full start-up wait and then resumes output with no action on `sd_n`.
- R9: A low `sd_n` moves the start-up, running and thermal-fault states to shutdown. A latched short fault does not move.
- R10: In reset, and for two clocks after `rst_n` rises, `out_en` is 0, `lowpwr` is 1 and both fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse |
| sd_n | input | 1 | Shutdown request, active low, asynchronous |
| short_det | input | 1 | Short-circuit detect from the output stage |
| temp_code | input | TEMP_W | Die temperature code in degrees |
| ramp_extra | input | EXTRA_W | Programmable extra start-up ticks |
| out_en | output | 1 | Modulator output-enable |
| lowpwr | output | 1 | Muted low-power indication (shutdown or short fault) |
| fault_short | output | 1 | Latched short-circuit fault |
| fault_therm | output | 1 | Thermal fault with hysteresis |

## Verification
Each output has a fixed latency after the input that changes it. An `sd_n` edge passes through two synchroniser flops, so the state follows on the third clock edge after it is sampled. A debounced short or a temperature crossing changes the fault bits on the next edge, and `out_en` follows one edge after `fault_therm`. The start-up wait ends on the edge after the last counted tick. The bench model steps through the same edges and compares all four outputs half a clock after every edge. Directed checks wait past the longest of these latencies, or stop short of the earliest completion when they test that something has not yet happened.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_RUN   = 3'd2,
    ST_SHORT = 3'd3,
    ST_HOT   = 3'd4
  } amp_state_e;

endpackage

// File: rtl/amp_sd_sync.sv
module amp_sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic sd_n_i,
  output logic sd_on_o,
  output logic sd_rise_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], sd_n_i};
  end

  // Reset value 0 keeps the amplifier in shutdown until a real release.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign sd_on_o   = sh_q[STAGES-1];
  assign sd_rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/amp_short_filt.sv
module amp_short_filt #(
  parameter int DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic short_i,
  output logic trip_o
);

  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          full;

  assign full = (cnt_q == CW'(DEB_TICKS));

  always_comb begin
    cnt_d = cnt_q;
    if (!short_i) begin
      cnt_d = '0;
    end else if (tick_i && !full) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign trip_o = full;

endmodule

// File: rtl/amp_therm_mon.sv
module amp_therm_mon #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_CODE = 150,
  parameter int HYST_CODE = 15
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);

  localparam int CLR_CODE = TRIP_CODE - HYST_CODE;

  logic hot_q;
  logic hot_d;
  logic above_trip;
  logic below_clr;

  assign above_trip = (temp_i > TEMP_W'(TRIP_CODE));
  assign below_clr  = (temp_i <= TEMP_W'(CLR_CODE));

  always_comb begin
    hot_d = hot_q;
    if (hot_q) begin
      if (below_clr) begin
        hot_d = 1'b0;
      end
    end else if (above_trip) begin
      hot_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
    end else begin
      hot_q <= hot_d;
    end
  end

  assign hot_o = hot_q;

endmodule

// File: rtl/amp_ramp_timer.sv
module amp_ramp_timer #(
  parameter int FIX_TICKS = 82,
  parameter int EXTRA_W   = 6
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [EXTRA_W-1:0] extra_i,
  output logic               done_o
);

  localparam int TW = $clog2(FIX_TICKS + (1 << EXTRA_W)) + 1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic [TW-1:0] target;
  logic          done;

  assign target = TW'(FIX_TICKS) + TW'(extra_i);
  assign done   = (cnt_q >= target);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i && !done) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = done;

endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import amp_guard_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int TRIP_CODE   = 150,
  parameter int HYST_CODE   = 15,
  parameter int DEB_TICKS   = 4,
  parameter int FIX_TICKS   = 82,
  parameter int EXTRA_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               sd_n,
  input  logic               short_det,
  input  logic [TEMP_W-1:0]  temp_code,
  input  logic [EXTRA_W-1:0] ramp_extra,
  output logic               out_en,
  output logic               lowpwr,
  output logic               fault_short,
  output logic               fault_therm
);

  // Reset: asserted at once, released on the second clock edge.
  logic [1:0] rst_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int = rst_q[1];

  logic sd_on;
  logic sd_rise;
  logic sc_trip;
  logic hot;
  logic ramp_done;
  logic ramp_run;

  amp_sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_int),
    .sd_n_i   (sd_n),
    .sd_on_o  (sd_on),
    .sd_rise_o(sd_rise)
  );

  amp_short_filt #(.DEB_TICKS(DEB_TICKS)) u_filt (
    .clk    (clk),
    .rst_ni (rst_int),
    .tick_i (tick),
    .short_i(short_det),
    .trip_o (sc_trip)
  );

  amp_therm_mon #(
    .TEMP_W   (TEMP_W),
    .TRIP_CODE(TRIP_CODE),
    .HYST_CODE(HYST_CODE)
  ) u_therm (
    .clk   (clk),
    .rst_ni(rst_int),
    .temp_i(temp_code),
    .hot_o (hot)
  );

  amp_ramp_timer #(
    .FIX_TICKS(FIX_TICKS),
    .EXTRA_W  (EXTRA_W)
  ) u_ramp (
    .clk    (clk),
    .rst_ni (rst_int),
    .run_i  (ramp_run),
    .tick_i (tick),
    .extra_i(ramp_extra),
    .done_o (ramp_done)
  );

  amp_state_e st_q;
  amp_state_e st_d;

  // Shutdown wins over faults, the short fault wins over the thermal one;
  // only a latched short ignores shutdown and waits for a rising edge.
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF: begin
        if (sd_on) st_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (!sd_on)         st_d = ST_OFF;
        else if (sc_trip)   st_d = ST_SHORT;
        else if (hot)       st_d = ST_HOT;
        else if (ramp_done) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (!sd_on)       st_d = ST_OFF;
        else if (sc_trip) st_d = ST_SHORT;
        else if (hot)     st_d = ST_HOT;
      end
      ST_SHORT: begin
        if (sd_rise) st_d = ST_RAMP;
      end
      ST_HOT: begin
        if (!sd_on)       st_d = ST_OFF;
        else if (sc_trip) st_d = ST_SHORT;
        else if (!hot)    st_d = ST_RAMP;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_q <= ST_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  assign ramp_run    = (st_q == ST_RAMP);
  assign out_en      = (st_q == ST_RUN);
  assign lowpwr      = (st_q == ST_OFF) || (st_q == ST_SHORT);
  assign fault_short = (st_q == ST_SHORT);
  assign fault_therm = hot;

endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
  input logic clk,
  input logic rst_ni,
  input logic sd_on,
  input logic sd_rise,
  input logic ramp_done,
  input logic out_en,
  input logic lowpwr,
  input logic fault_short,
  input logic fault_therm
);

  // R2
  out_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    out_en |-> (!lowpwr && !fault_short));

  // R9
  sd_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !sd_on |=> (lowpwr && !out_en));

  // R5
  short_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(fault_short) |-> $past(sd_rise));

  // R7
  therm_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_therm |=> !out_en);

  // R3
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(out_en) |-> $past(ramp_done));

  // R4
  short_mute_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fault_short |-> (!out_en && lowpwr));

endmodule

bind amp_guard_ctrl amp_guard_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_int),
  .sd_on      (sd_on),
  .sd_rise    (sd_rise),
  .ramp_done  (ramp_done),
  .out_en     (out_en),
  .lowpwr     (lowpwr),
  .fault_short(fault_short),
  .fault_therm(fault_therm)
);

// File: tb/amp_guard_ctrl_test.sv
`timescale 1ns/1ps
module amp_guard_ctrl_test;

  localparam int TEMP_W  = 8;
  localparam int TRIP    = 150;
  localparam int HYST    = 15;
  localparam int DEB     = 4;
  localparam int FIX     = 82;
  localparam int EXTRA_W = 6;
  localparam int TDIV    = 4;
  localparam int WDOG    = 50000;

  localparam int M_OFF = 0, M_RAMP = 1, M_RUN = 2, M_SHORT = 3, M_HOT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic sd_n;
  logic short_det;
  logic [TEMP_W-1:0]  temp_code;
  logic [EXTRA_W-1:0] ramp_extra;
  logic out_en, lowpwr, fault_short, fault_therm;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int tdiv_cnt = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  amp_guard_ctrl #(
    .TEMP_W(TEMP_W), .TRIP_CODE(TRIP), .HYST_CODE(HYST),
    .DEB_TICKS(DEB), .FIX_TICKS(FIX), .EXTRA_W(EXTRA_W), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sd_n(sd_n),
    .short_det(short_det), .temp_code(temp_code), .ramp_extra(ramp_extra),
    .out_en(out_en), .lowpwr(lowpwr),
    .fault_short(fault_short), .fault_therm(fault_therm)
  );

  // Tick every TDIV clocks, driven away from the active edge.
  always @(negedge clk) begin
    tdiv_cnt <= (tdiv_cnt + 1) % TDIV;
    tick     <= (tdiv_cnt == TDIV - 1);
  end

  // Behavioural reference model.
  int  mst;
  int  dcnt;
  int  tcnt;
  bit  mhot;
  bit  sdq[$];
  bit  rq[$];

  task automatic model_reset();
    mst = M_OFF; dcnt = 0; tcnt = 0; mhot = 1'b0;
    sdq = '{1'b0, 1'b0, 1'b0};
    rq  = '{1'b0, 1'b0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      if (rq[1]) begin
        bit sd_on, rise, trip, rdone;
        int nst;
        sd_on = sdq[1];
        rise  = sdq[1] && !sdq[2];
        trip  = (dcnt == DEB);
        rdone = (tcnt >= FIX + int'(ramp_extra));
        nst = mst;
        if (mst == M_OFF) begin
          if (sd_on) nst = M_RAMP;
        end else if (mst == M_SHORT) begin
          if (rise) nst = M_RAMP;
        end else if (!sd_on) nst = M_OFF;
        else if (trip) nst = M_SHORT;
        else if (mst == M_HOT) begin
          if (!mhot) nst = M_RAMP;
        end else if (mhot) nst = M_HOT;
        else if (mst == M_RAMP && rdone) nst = M_RUN;
        if (mst != M_RAMP) tcnt = 0;
        else if (tick && !rdone) tcnt = tcnt + 1;
        if (!short_det) dcnt = 0;
        else if (tick && dcnt < DEB) dcnt = dcnt + 1;
        if (mhot) begin
          if (int'(temp_code) <= TRIP - HYST) mhot = 1'b0;
        end else if (int'(temp_code) > TRIP) mhot = 1'b1;
        sdq.push_front(sd_n);
        void'(sdq.pop_back());
        mst = nst;
      end
      rq.push_front(1'b1);
      void'(rq.pop_back());
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Lockstep comparison, half a clock after every edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done_flag) begin
      chk("R2", "out_en vs model",      out_en,      mst == M_RUN);
      chk("R1", "lowpwr vs model",      lowpwr,      (mst == M_OFF) || (mst == M_SHORT));
      chk("R4", "fault_short vs model", fault_short, mst == M_SHORT);
      chk("R7", "fault_therm vs model", fault_therm, mhot);
    end
    if (cyc > WDOG && !done_flag) begin
      done_flag = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sd_n = 1'b0; short_det = 1'b0;
    temp_code = 8'd25; ramp_extra = 6'd3; tick = 1'b0;
    wait_n(3);
    // R10 reset state
    chk("R10", "out_en in reset", out_en, 1'b0);
    chk("R10", "lowpwr in reset", lowpwr, 1'b1);
    chk("R10", "fault_short in reset", fault_short, 1'b0);
    chk("R10", "fault_therm in reset", fault_therm, 1'b0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10", "lowpwr after release", lowpwr, 1'b1);
    wait_n(20);
    chk("R1", "held in shutdown", lowpwr, 1'b1);
    chk("R1", "no output in shutdown", out_en, 1'b0);

    // Start-up with extra = 3
    sd_n = 1'b1;
    wait_n((FIX + 3 - 1) * TDIV);
    chk("R3", "still starting", out_en, 1'b0);
    wait_n(6 * TDIV);
    chk("R2", "running after wait", out_en, 1'b1);
    chk("R2", "lowpwr off in run", lowpwr, 1'b0);

    // Short glitch of two ticks
    short_det = 1'b1;
    wait_n(2 * TDIV);
    short_det = 1'b0;
    wait_n(TDIV);
    chk("R4", "glitch ignored fault", fault_short, 1'b0);
    chk("R4", "glitch ignored output", out_en, 1'b1);

    // Sustained short
    short_det = 1'b1;
    wait_n(6 * TDIV);
    chk("R4", "short trips", fault_short, 1'b1);
    chk("R4", "output off on short", out_en, 1'b0);
    chk("R4", "lowpwr on short", lowpwr, 1'b1);
    short_det = 1'b0;
    wait_n(40);
    chk("R5", "latched after short gone", fault_short, 1'b1);
    sd_n = 1'b0;
    wait_n(10);
    chk("R5", "latched while sd low", fault_short, 1'b1);
    sd_n = 1'b1;
    wait_n(6);
    chk("R5", "cleared by toggle", fault_short, 1'b0);
    chk("R5", "start-up after toggle", lowpwr, 1'b0);
    ramp_extra = 6'd10;
    wait_n((FIX + 10 + 3) * TDIV);
    chk("R3", "running with extra 10", out_en, 1'b1);

    // Short still present at release
    short_det = 1'b1;
    wait_n(6 * TDIV);
    chk("R6", "short trips again", fault_short, 1'b1);
    sd_n = 1'b0;
    wait_n(10);
    sd_n = 1'b1;
    wait_n(12);
    chk("R6", "re-trip after toggle", fault_short, 1'b1);
    chk("R6", "no output on re-trip", out_en, 1'b0);
    short_det = 1'b0;
    sd_n = 1'b0;
    wait_n(10);
    ramp_extra = 6'd0;
    sd_n = 1'b1;
    wait_n((FIX - 1) * TDIV);
    chk("R3", "still starting extra 0", out_en, 1'b0);
    wait_n(5 * TDIV);
    chk("R3", "running extra 0", out_en, 1'b1);

    // Thermal hysteresis
    temp_code = 8'd150;
    wait_n(10);
    chk("R7", "150 does not trip", fault_therm, 1'b0);
    chk("R7", "150 keeps output", out_en, 1'b1);
    temp_code = 8'd151;
    wait_n(3);
    chk("R7", "151 trips", fault_therm, 1'b1);
    chk("R7", "output off when hot", out_en, 1'b0);
    temp_code = 8'd140;
    wait_n(20);
    chk("R7", "140 holds fault", fault_therm, 1'b1);
    chk("R7", "140 keeps output off", out_en, 1'b0);
    temp_code = 8'd136;
    wait_n(5);
    chk("R7", "136 holds fault", fault_therm, 1'b1);
    temp_code = 8'd135;
    wait_n(3);
    chk("R7", "135 clears", fault_therm, 1'b0);
    chk("R8", "restart goes via start-up", out_en, 1'b0);
    chk("R8", "not low power in start-up", lowpwr, 1'b0);
    wait_n((FIX + 2) * TDIV);
    chk("R8", "resumed by itself", out_en, 1'b1);

    // Shutdown priority over thermal fault
    temp_code = 8'd200;
    wait_n(3);
    sd_n = 1'b0;
    wait_n(5);
    chk("R9", "shutdown from thermal", lowpwr, 1'b1);
    chk("R9", "no short flag", fault_short, 1'b0);
    temp_code = 8'd25;
    wait_n(5);
    chk("R9", "stays off after cooling", lowpwr, 1'b1);
    chk("R9", "thermal cleared", fault_therm, 1'b0);
    sd_n = 1'b1;
    wait_n((FIX + 2) * TDIV);
    chk("R2", "running again", out_en, 1'b1);
    sd_n = 1'b0;
    wait_n(4);
    chk("R1", "output off within four clocks", out_en, 1'b0);
    chk("R1", "lowpwr on", lowpwr, 1'b1);

    wait_n(2);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule